// File: doc/BRIEF.md
# Accumulator Machine Datapath

This block is the register-and-arithmetic core of a small accumulator computer. It holds an address register, an accumulator (data) register and an instruction counter, and it combines them through an add-or-and arithmetic unit. The accumulator always feeds the arithmetic unit's first operand. A selector feeds the second operand from either the memory read bus or the accumulator. Another selector loads the address register from either the instruction word or the arithmetic result.

An external decoder drives every control line. The block turns them into next-state updates on each rising clock edge. The instruction counter is the instruction address. The address register is the data memory address. The arithmetic result serves as the memory write data. Two flags, zero and negative, describe that result.

Top module: `acc_datapath`

## Requirements
- R1: With `rst` high at a rising edge, `pc` becomes 0 whatever `ld_pc` and `inc_pc` are. The address register and accumulator keep their values.
- R2: With `rst` low and `ld_pc` high, `pc` takes the value `a_addr` had before the edge. This holds even if `inc_pc` is also high.
- R3: With `rst` and `ld_pc` low and `inc_pc` high, `pc` advances by one modulo 2^WIDTH, so all-ones wraps to 0.
- R4: With `rst`, `ld_pc` and `inc_pc` all low, `pc` keeps its value.
- R5: With `ld_a` high, the address register loads `rom_word` when `sel_a_rom`=1 and the arithmetic result when `sel_a_rom`=0. With `ld_a` low it holds, regardless of `rom_word`.
- R6: With `ld_d` high, the accumulator loads the arithmetic result. With `ld_d` low it holds.
- R7: The first operand X is the accumulator. The second operand Y is `mem_rdata` when `sel_y_mem`=1 and the accumulator when `sel_y_mem`=0.
- R8: Each operand is first forced to 0 if its zero bit is set (`zx`/`zy`). It is then bitwise inverted if its invert bit is set (`nx`/`ny`). With `f_add`=1 the core result is X+Y+`cin` modulo 2^WIDTH; with `f_add`=0 it is X AND Y. With `neg_out`=1 the result is bitwise inverted. The final value appears on `alu_out` in the same cycle.
- R9: `zr` is 1 exactly when `alu_out` is 0. `ng` equals the top bit of `alu_out`.
- R10: `a_addr` is the address register's present value. `alu_out` is the present arithmetic result, with no register stage.
- R11: With both `ld_a` (and `sel_a_rom`=0) and `ld_d` high, both registers take the same arithmetic result at one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high counter clear |
| rom_word | input | WIDTH | Instruction word from program memory |
| mem_rdata | input | WIDTH | Data memory read value |
| sel_y_mem | input | 1 | Y operand: 1 memory, 0 accumulator |
| sel_a_rom | input | 1 | Address register source: 1 instruction word, 0 result |
| ld_a | input | 1 | Address register load enable |
| ld_d | input | 1 | Accumulator load enable |
| ld_pc | input | 1 | Counter load from address register |
| inc_pc | input | 1 | Counter increment enable |
| zx | input | 1 | Zero X operand |
| nx | input | 1 | Invert X operand |
| zy | input | 1 | Zero Y operand |
| ny | input | 1 | Invert Y operand |
| f_add | input | 1 | 1 add, 0 bitwise AND |
| neg_out | input | 1 | Invert result |
| cin | input | 1 | Adder carry in |
| pc | output | WIDTH | Instruction address |
| a_addr | output | WIDTH | Data memory address |
| alu_out | output | WIDTH | Arithmetic result and memory write data |
| zr | output | 1 | Result is zero |
| ng | output | 1 | Result top bit |

## Verification
The bench uses a 4-bit configuration. It loads every accumulator value and sweeps every control combination against every Y value from both sources. A slip in the zero/invert ordering or the carry-in would corrupt part of that space, and so would a dropped wrap bit. Flags wired to the wrong bit would show up the same way. A short program sequence applies reset with load and increment asserted together; a wrong priority shows up as a nonzero or jumped counter. The sequence also asserts load and increment together, which a reversed priority turns into an increment. It wraps the counter from all-ones, which a design with a missing wrap would fail. It also changes the instruction word while the address load is low, which a selector without feedback would let leak into the register.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic f_add;
    logic neg_out;
    logic cin;
  } alu_ctl_t;
endpackage

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  alu_ctl_t         ctl,
  output logic [WIDTH-1:0] res,
  output logic             zr,
  output logic             ng
);
  localparam int MSB = WIDTH - 1;

  logic [1:0][WIDTH-1:0] raw;
  logic [1:0][WIDTH-1:0] cond;
  logic [1:0]            zero_bit;
  logic [1:0]            inv_bit;
  logic [WIDTH-1:0]      core;

  assign raw[0]      = x_in;
  assign raw[1]      = y_in;
  assign zero_bit[0] = ctl.zx;
  assign zero_bit[1] = ctl.zy;
  assign inv_bit[0]  = ctl.nx;
  assign inv_bit[1]  = ctl.ny;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [WIDTH-1:0] zeroed;
    assign zeroed  = zero_bit[k] ? '0 : raw[k];
    assign cond[k] = inv_bit[k] ? ~zeroed : zeroed;
  end

  always_comb begin
    if (ctl.f_add) core = cond[0] + cond[1] + {{MSB{1'b0}}, ctl.cin};
    else           core = cond[0] & cond[1];
  end

  assign res = ctl.neg_out ? ~core : core;
  assign zr  = (res == '0);
  assign ng  = res[MSB];
endmodule

// File: rtl/acc_hold_reg.sv
`timescale 1ns/1ps
module acc_hold_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  assign nxt = ld ? d : q;

  always_ff @(posedge clk) q <= nxt;
endmodule

// File: rtl/acc_pc.sv
`timescale 1ns/1ps
module acc_pc #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             inc,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] pc
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (ld)  pc <= ld_val;
    else if (inc) pc <= pc + ONE;
  end
endmodule

// File: rtl/acc_datapath.sv
`timescale 1ns/1ps
module acc_datapath
  import acc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rom_word,
  input  logic [WIDTH-1:0] mem_rdata,
  input  logic             sel_y_mem,
  input  logic             sel_a_rom,
  input  logic             ld_a,
  input  logic             ld_d,
  input  logic             ld_pc,
  input  logic             inc_pc,
  input  logic             zx,
  input  logic             nx,
  input  logic             zy,
  input  logic             ny,
  input  logic             f_add,
  input  logic             neg_out,
  input  logic             cin,
  output logic [WIDTH-1:0] pc,
  output logic [WIDTH-1:0] a_addr,
  output logic [WIDTH-1:0] alu_out,
  output logic             zr,
  output logic             ng
);
  alu_ctl_t         ctl;
  logic [WIDTH-1:0] d_q;
  logic [WIDTH-1:0] y_opnd;
  logic [WIDTH-1:0] a_src;

  assign ctl    = '{zx: zx, nx: nx, zy: zy, ny: ny,
                    f_add: f_add, neg_out: neg_out, cin: cin};
  assign y_opnd = sel_y_mem ? mem_rdata : d_q;
  assign a_src  = sel_a_rom ? rom_word : alu_out;

  acc_alu #(.WIDTH(WIDTH)) u_alu (
    .x_in (d_q),
    .y_in (y_opnd),
    .ctl  (ctl),
    .res  (alu_out),
    .zr   (zr),
    .ng   (ng)
  );

  acc_hold_reg #(.WIDTH(WIDTH)) u_areg (
    .clk (clk),
    .ld  (ld_a),
    .d   (a_src),
    .q   (a_addr)
  );

  acc_hold_reg #(.WIDTH(WIDTH)) u_dreg (
    .clk (clk),
    .ld  (ld_d),
    .d   (alu_out),
    .q   (d_q)
  );

  acc_pc #(.WIDTH(WIDTH)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld_pc),
    .inc    (inc_pc),
    .ld_val (a_addr),
    .pc     (pc)
  );
endmodule

// File: rtl/acc_datapath_chk.sv
`timescale 1ns/1ps
module acc_datapath_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] rom_word,
  input logic             sel_a_rom,
  input logic             ld_a,
  input logic             ld_d,
  input logic             ld_pc,
  input logic             inc_pc,
  input logic             zx,
  input logic             nx,
  input logic             zy,
  input logic             ny,
  input logic             f_add,
  input logic             neg_out,
  input logic             cin,
  input logic [WIDTH-1:0] pc,
  input logic [WIDTH-1:0] a_addr,
  input logic [WIDTH-1:0] alu_out,
  input logic [WIDTH-1:0] d_q
);
  assert_pc_clear_R1: assert property (@(posedge clk)
    rst |=> pc == '0);

  assert_pc_load_R2: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> pc == $past(a_addr));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_pc && inc_pc) |=> pc == WIDTH'($past(pc) + 1'b1));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_pc && !inc_pc) |=> $stable(pc));

  assert_a_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(a_addr));

  assert_a_rom_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_a && sel_a_rom) |=> a_addr == $past(rom_word));

  assert_d_load_R6: assert property (@(posedge clk) disable iff (rst)
    ld_d |=> d_q == $past(alu_out));

  assert_d_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_d |=> $stable(d_q));

  assert_x_is_acc_R7: assert property (@(posedge clk) disable iff (rst)
    (!zx && !nx && zy && !ny && f_add && !neg_out && !cin) |-> alu_out == d_q);
endmodule

bind acc_datapath acc_datapath_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .rom_word(rom_word), .sel_a_rom(sel_a_rom),
  .ld_a(ld_a), .ld_d(ld_d), .ld_pc(ld_pc), .inc_pc(inc_pc),
  .zx(zx), .nx(nx), .zy(zy), .ny(ny), .f_add(f_add), .neg_out(neg_out),
  .cin(cin), .pc(pc), .a_addr(a_addr), .alu_out(alu_out), .d_q(d_q)
);

// File: tb/acc_datapath_bench.sv
`timescale 1ns/1ps
module acc_datapath_bench;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst, sel_y_mem, sel_a_rom, ld_a, ld_d, ld_pc, inc_pc;
  logic zx, nx, zy, ny, f_add, neg_out, cin;
  logic [W-1:0] rom_word, mem_rdata, pc, a_addr, alu_out;
  logic zr, ng;

  int errors = 0;
  int checks = 0;
  int exp_pc, exp_a, exp_d;

  always #2 clk = ~clk;

  acc_datapath #(.WIDTH(W)) u_acc_datapath (
    .clk(clk), .rst(rst), .rom_word(rom_word), .mem_rdata(mem_rdata),
    .sel_y_mem(sel_y_mem), .sel_a_rom(sel_a_rom), .ld_a(ld_a), .ld_d(ld_d),
    .ld_pc(ld_pc), .inc_pc(inc_pc), .zx(zx), .nx(nx), .zy(zy), .ny(ny),
    .f_add(f_add), .neg_out(neg_out), .cin(cin), .pc(pc), .a_addr(a_addr),
    .alu_out(alu_out), .zr(zr), .ng(ng)
  );

  function automatic int memv(input int a);
    return (3 * a + 1) & MASK;
  endfunction

  function automatic int ref_alu(input int x, input int y, input logic [6:0] c);
    int xo, yo, r;
    xo = c[6] ? 0 : x;
    if (c[5]) xo = MASK - xo;
    yo = c[4] ? 0 : y;
    if (c[3]) yo = MASK - yo;
    r = c[2] ? ((xo + yo + int'(c[0])) % (MASK + 1)) : (xo & yo);
    if (c[1]) r = MASK - r;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [6:0] c);
    {zx, nx, zy, ny, f_add, neg_out, cin} = c;
  endtask

  task automatic idle();
    rst = 0; ld_a = 0; ld_d = 0; ld_pc = 0; inc_pc = 0;
  endtask

  task automatic peek_d(input string req);
    sel_y_mem = 0;
    set_ctl(7'b0010100);
    #0.5;
    chk(req, int'(alu_out), exp_d);
  endtask

  task automatic clock_and_check(input string req, input bit full);
    int r, n_pc, n_a, n_d;
    mem_rdata = W'(memv(exp_a));
    r = ref_alu(exp_d, sel_y_mem ? int'(mem_rdata) : exp_d,
                {zx, nx, zy, ny, f_add, neg_out, cin});
    n_pc = rst ? 0 : ld_pc ? exp_a : inc_pc ? ((exp_pc + 1) & MASK) : exp_pc;
    n_a  = ld_a ? (sel_a_rom ? int'(rom_word) : r) : exp_a;
    n_d  = ld_d ? r : exp_d;
    @(posedge clk);
    #1;
    exp_pc = n_pc; exp_a = n_a; exp_d = n_d;
    idle();
    chk({req, " pc"}, int'(pc), exp_pc);
    if (full) begin
      chk({req, " addr"}, int'(a_addr), exp_a);
      peek_d({req, " acc"});
    end
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rom_word = '0; mem_rdata = '0; sel_y_mem = 0; sel_a_rom = 0;
    set_ctl(7'b0);
    exp_pc = 0; exp_a = 0; exp_d = 0;

    // R1 reset beats load and increment
    @(negedge clk); rst = 1; ld_pc = 1; inc_pc = 1;
    clock_and_check("R1", 0);

    // R11 both registers load result 1
    @(negedge clk); ld_a = 1; ld_d = 1; sel_a_rom = 0; inc_pc = 1;
    set_ctl(7'b1010101);
    clock_and_check("R11", 1);

    // R5 constant into address register
    @(negedge clk); ld_a = 1; sel_a_rom = 1; rom_word = 4'd7; inc_pc = 1;
    clock_and_check("R5", 1);

    // R7 accumulator = memory
    @(negedge clk); ld_d = 1; sel_y_mem = 1; inc_pc = 1; set_ctl(7'b1000100);
    clock_and_check("R7", 1);

    @(negedge clk); ld_a = 1; sel_a_rom = 1; rom_word = 4'd2; inc_pc = 1;
    clock_and_check("R5", 1);

    // R8 and R6: accumulator += memory
    @(negedge clk); ld_d = 1; sel_y_mem = 1; inc_pc = 1; set_ctl(7'b0000100);
    clock_and_check("R8", 1);

    @(negedge clk); ld_a = 1; sel_a_rom = 1; rom_word = 4'd9; inc_pc = 1;
    clock_and_check("R5", 1);

    // R2 jump: load beats increment
    @(negedge clk); ld_pc = 1; inc_pc = 1;
    clock_and_check("R2", 1);

    // R4 hold, R5 instruction word ignored while load low
    @(negedge clk); rom_word = 4'd3; sel_a_rom = 1;
    clock_and_check("R4", 1);

    // R1 registers untouched by reset
    @(negedge clk); rst = 1; ld_pc = 1; inc_pc = 1;
    clock_and_check("R1", 1);

    // R3 wrap from all-ones
    @(negedge clk); ld_a = 1; sel_a_rom = 1; rom_word = 4'(MASK);
    clock_and_check("R5", 1);
    @(negedge clk); ld_pc = 1;
    clock_and_check("R2", 1);
    @(negedge clk); inc_pc = 1;
    clock_and_check("R3", 1);
    chk("R3 wrap", int'(pc), 0);

    // R5 address register from result (accumulator + 1)
    @(negedge clk); ld_a = 1; sel_a_rom = 0; set_ctl(7'b0010101);
    clock_and_check("R5", 1);

    // R7 R8 R9 R10 sweep
    for (int a = 0; a <= MASK; a++) begin
      @(negedge clk); ld_a = 1; sel_a_rom = 1; rom_word = W'(a);
      clock_and_check("R10", 1);
      @(negedge clk); ld_d = 1; sel_y_mem = 1; set_ctl(7'b1000100);
      clock_and_check("R6", 1);
      for (int c = 0; c < 128; c++) begin
        for (int y = 0; y <= MASK + 1; y++) begin
          int e;
          set_ctl(7'(c));
          if (y <= MASK) begin
            sel_y_mem = 1; mem_rdata = W'(y);
            e = ref_alu(exp_d, y, 7'(c));
          end else begin
            sel_y_mem = 0;
            e = ref_alu(exp_d, exp_d, 7'(c));
          end
          #1;
          chk("R8", int'(alu_out), e);
          chk("R9 zero", int'(zr), int'(e == 0));
          chk("R9 neg", int'(ng), (e >> (W - 1)) & 1);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule